// File: doc/BRIEF.md
# Bitfield and Mask Execution Unit

This block is the integer execution slice of a RISC pipeline that handles bitwise AND-class operations and all bitfield work on 32-bit words. Two kinds of operation share it.

The logic forms combine the first operand with either a second register or a 16-bit immediate. When the immediate is used, the other half of the word is filled with ones for the AND forms, so that half of the source passes through unchanged. For the mask forms it is filled with zeros, so that half of the result is cleared.

The bitfield forms extract a field with sign or zero extension, place a field at an offset, or force a field to ones or zeros. Width and offset come from one packed specifier, taken either from the second register or from the low bits of the immediate. Shifts have no separate unit: a left shift is a full-width make, a logical right shift is a full-width unsigned extract, and an arithmetic right shift is a full-width signed extract.

Each operation is computed in one cycle and captured in a single output register. The result therefore appears on the clock edge that follows the one sampling the inputs. The block has no states beyond that register: its one stage is loaded on every clock and cleared by reset.

Top module: `bfu_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0. After reset, `result` holds the outcome of the inputs sampled at the previous rising clock edge.
- R2: Operation code 0 gives `src_a & src_b`. Code 1 gives `src_a & ~src_b`.
- R3: Code 2 gives `src_a & {16'hFFFF, imm}`, so bits 31:16 of `src_a` pass through unchanged.
- R4: Code 3 gives `src_a & {imm, 16'hFFFF}`, so bits 15:0 of `src_a` pass through unchanged.
- R5: Code 4 gives `src_a & {16'h0000, imm}`. Code 5 gives `src_a & {imm, 16'h0000}`.
- R6: The field specifier has its width in bits 9:5 and its offset in bits 4:0. A width value of 0 means 32. The specifier is `imm[9:0]` when `use_imm` is 1 and `src_b[9:0]` otherwise, and all of its other bits are ignored.
- R7: Code 7 (unsigned extract) gives `src_a >> offset`, truncated to the field width and zero-extended.
- R8: Code 6 (signed extract) gives `src_a >> offset`, truncated to the field width and sign-extended from the top bit of the field.
- R9: Code 8 (make) gives the low width bits of `src_a` placed at the offset, with every other bit 0.
- R10: Code 9 (set field) forces the field bits of `src_a` to 1. Code 10 (clear field) forces them to 0. All other bits of `src_a` pass through unchanged.
- R11: A field with offset plus width above 32 is clipped at bit 31. When extracting, the bits past bit 31 read as 0 for the unsigned form and as a copy of bit 31 for the signed form.
- R12: The full-width field forms act as shifts: make acts as a left shift, unsigned extract as a logical right shift, and signed extract as an arithmetic right shift, each by the offset.
- R13: Codes 11 to 15 give 0. The logic codes 0 to 5 ignore `use_imm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Field specifier from the immediate (1) or from `src_b` (0) |
| src_a | input | 32 | Source operand |
| src_b | input | 32 | Second register operand or packed specifier |
| imm | input | 16 | Immediate operand |
| result | output | 32 | Registered result |

## Verification
The assertions assume that every rising edge after reset loads a new result from inputs that were stable around that edge. They do not check the first edge after reset is released, because that edge sampled inputs driven during reset. The stimulus changes the inputs only on falling edges and lets each operation settle for a full cycle. Random operation codes cover the whole 4-bit space, including the unused codes. Random specifiers cover every width and offset, so clipped fields arise naturally.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'd0,
        OP_ANDC   = 4'd1,
        OP_ANDIL  = 4'd2,
        OP_ANDIU  = 4'd3,
        OP_MASKL  = 4'd4,
        OP_MASKU  = 4'd5,
        OP_EXTS   = 4'd6,
        OP_EXTU   = 4'd7,
        OP_MAKE   = 4'd8,
        OP_SETF   = 4'd9,
        OP_CLRF   = 4'd10
    } bfu_op_e;

    function automatic logic is_field_op(input logic [3:0] code);
        return (code >= 4'd6) && (code <= 4'd10);
    endfunction

endpackage

// File: rtl/bfu_logic.sv
module bfu_logic #(
    parameter int XLEN = 32,
    parameter int HALF = XLEN / 2
) (
    input  logic [3:0]      op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [HALF-1:0] imm,
    output logic [XLEN-1:0] logic_out
);
    import bfu_pkg::*;

    localparam logic [HALF-1:0] ONES  = {HALF{1'b1}};
    localparam logic [HALF-1:0] ZEROS = {HALF{1'b0}};

    logic [XLEN-1:0] operand;

    always_comb begin
        operand = '0;
        unique case (op_sel)
            OP_AND:   operand = src_b;
            OP_ANDC:  operand = ~src_b;
            OP_ANDIL: operand = {ONES, imm};
            OP_ANDIU: operand = {imm, ONES};
            OP_MASKL: operand = {ZEROS, imm};
            OP_MASKU: operand = {imm, ZEROS};
            default:  operand = '0;
        endcase
    end

    assign logic_out = src_a & operand;

endmodule

// File: rtl/bfu_spec.sv
module bfu_spec #(
    parameter int XLEN = 32,
    parameter int FW   = $clog2(XLEN)
) (
    input  logic              use_imm,
    input  logic [2*FW-1:0]   spec_reg,
    input  logic [2*FW-1:0]   spec_imm,
    output logic [FW:0]       fld_width,
    output logic [FW-1:0]     fld_offset,
    output logic [XLEN-1:0]   low_mask,
    output logic [XLEN-1:0]   place_mask
);
    logic [2*FW-1:0] spec;
    logic [FW-1:0]   raw_width;

    assign spec       = use_imm ? spec_imm : spec_reg;
    assign raw_width  = spec[2*FW-1:FW];
    assign fld_offset = spec[FW-1:0];
    assign fld_width  = (raw_width == '0) ? (FW+1)'(XLEN) : {1'b0, raw_width};

    for (genvar i = 0; i < XLEN; i++) begin : g_mask
        assign low_mask[i] = ((FW+1)'(i) < fld_width);
    end

    assign place_mask = low_mask << fld_offset;

endmodule

// File: rtl/bfu_field.sv
module bfu_field #(
    parameter int XLEN = 32,
    parameter int FW   = $clog2(XLEN)
) (
    input  logic [3:0]      op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [FW:0]     fld_width,
    input  logic [FW-1:0]   fld_offset,
    input  logic [XLEN-1:0] low_mask,
    input  logic [XLEN-1:0] place_mask,
    output logic [XLEN-1:0] field_out
);
    import bfu_pkg::*;

    logic [XLEN-1:0] shr_log;
    logic [XLEN-1:0] shr_ari;
    logic [FW:0]     top_idx;
    logic            sign_bit;

    assign shr_log  = src_a >> fld_offset;
    assign shr_ari  = XLEN'($signed(src_a) >>> fld_offset);
    assign top_idx  = fld_width - 1'b1;
    assign sign_bit = shr_ari[top_idx[FW-1:0]];

    always_comb begin
        field_out = '0;
        unique case (op_sel)
            OP_EXTU: field_out = shr_log & low_mask;
            OP_EXTS: field_out = (shr_ari & low_mask) | (sign_bit ? ~low_mask : '0);
            OP_MAKE: field_out = (src_a & low_mask) << fld_offset;
            OP_SETF: field_out = src_a | place_mask;
            OP_CLRF: field_out = src_a & ~place_mask;
            default: field_out = '0;
        endcase
    end

endmodule

// File: rtl/bfu_unit.sv
module bfu_unit #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic              use_imm,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [XLEN/2-1:0] imm,
    output logic [XLEN-1:0]   result
);
    import bfu_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int FW   = $clog2(XLEN);

    logic [XLEN-1:0] logic_out;
    logic [XLEN-1:0] field_out;
    logic [XLEN-1:0] next_result;
    logic [FW:0]     fld_width;
    logic [FW-1:0]   fld_offset;
    logic [XLEN-1:0] low_mask;
    logic [XLEN-1:0] place_mask;

    bfu_logic #(.XLEN(XLEN), .HALF(HALF)) u_logic (
        .op_sel    (op_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .imm       (imm),
        .logic_out (logic_out)
    );

    bfu_spec #(.XLEN(XLEN), .FW(FW)) u_spec (
        .use_imm    (use_imm),
        .spec_reg   (src_b[2*FW-1:0]),
        .spec_imm   (imm[2*FW-1:0]),
        .fld_width  (fld_width),
        .fld_offset (fld_offset),
        .low_mask   (low_mask),
        .place_mask (place_mask)
    );

    bfu_field #(.XLEN(XLEN), .FW(FW)) u_field (
        .op_sel     (op_sel),
        .src_a      (src_a),
        .fld_width  (fld_width),
        .fld_offset (fld_offset),
        .low_mask   (low_mask),
        .place_mask (place_mask),
        .field_out  (field_out)
    );

    always_comb begin
        if (is_field_op(op_sel)) begin
            next_result = field_out;
        end else if (op_sel <= 4'd5) begin
            next_result = logic_out;
        end else begin
            next_result = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= next_result;
        end
    end

endmodule

// File: rtl/bfu_unit_chk.sv
module bfu_unit_chk #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic              use_imm,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [XLEN/2-1:0] imm,
    input  logic [XLEN-1:0]   result
);
    localparam int HALF = XLEN / 2;

    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (result == '0);
        end
    end

    assert_and_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd0) |-> result == ($past(src_a) & $past(src_b)));

    assert_andc_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd1) |-> (result & $past(src_b)) == '0);

    assert_upper_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd2) |-> result[XLEN-1:HALF] == $past(src_a[XLEN-1:HALF]));

    assert_lower_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd3) |-> result[HALF-1:0] == $past(src_a[HALF-1:0]));

    assert_mask_lo_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd4) |-> result[XLEN-1:HALF] == '0);

    assert_mask_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd5) |-> result[HALF-1:0] == '0);

    assert_set_keeps_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd9) |-> (result & $past(src_a)) == $past(src_a));

    assert_clr_adds_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 4'd10) |-> (result & ~$past(src_a)) == '0);

    assert_unused_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) >= 4'd11) |-> result == '0);

endmodule

bind bfu_unit bfu_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bfu_unit_test.sv
module bfu_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    bfu_unit uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
        .src_a(src_a), .src_b(src_b), .imm(imm), .result(result)
    );

    function automatic logic [31:0] ref_model(input logic [3:0] op, input logic ui,
        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
        logic [9:0]  sp;
        int          w, o, pos;
        logic [31:0] r;
        logic        topb;
        sp = ui ? im[9:0] : b[9:0];
        w  = (sp[9:5] == 0) ? 32 : int'(sp[9:5]);
        o  = int'(sp[4:0]);
        r  = '0;
        case (op)
            4'd0: r = a & b;
            4'd1: r = a & ~b;
            4'd2: r = a & {16'hFFFF, im};
            4'd3: r = a & {im, 16'hFFFF};
            4'd4: r = a & {16'h0000, im};
            4'd5: r = a & {im, 16'h0000};
            4'd6, 4'd7: begin
                topb = 1'b0;
                for (int i = 0; i < 32; i++) begin
                    if (i < w) begin
                        pos = i + o;
                        r[i] = (pos < 32) ? a[pos] : ((op == 4'd6) ? a[31] : 1'b0);
                        topb = r[i];
                    end else begin
                        r[i] = (op == 4'd6) ? topb : 1'b0;
                    end
                end
            end
            4'd8: for (int i = 0; i < 32; i++)
                      r[i] = (i >= o && i - o < w) ? a[i - o] : 1'b0;
            4'd9: for (int i = 0; i < 32; i++)
                      r[i] = (i >= o && i - o < w) ? 1'b1 : a[i];
            4'd10: for (int i = 0; i < 32; i++)
                      r[i] = (i >= o && i - o < w) ? 1'b0 : a[i];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6: return "R8";
            4'd7: return "R7";
            4'd8: return "R9";
            4'd9, 4'd10: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic ui, input logic [31:0] a,
        input logic [31:0] b, input logic [15:0] im, input string req, input logic [31:0] exp);
        @(negedge clk);
        op_sel = op; use_imm = ui; src_a = a; src_b = b; imm = im;
        @(negedge clk);
        check(req, result, exp);
    endtask

    task automatic run_model(input logic [3:0] op, input logic ui, input logic [31:0] a,
        input logic [31:0] b, input logic [15:0] im, input string req);
        run(op, ui, a, b, im, req, ref_model(op, ui, a, b, im));
    endtask

    function automatic logic [15:0] spec(input int w, input int o);
        return 16'((w & 31) << 5 | (o & 31));
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2ms;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        src_a = 32'hDEAD_BEEF; src_b = 32'h1234_5678; op_sel = 4'd0;
        repeat (3) @(negedge clk);
        check("R1 reset", result, 32'h0);
        rst_n = 1'b1;

        run(4'd0, 1'b1, 32'hF0F0_1234, 32'hFF00_00FF, 16'h0, "R2 and", 32'hF000_0034);
        run(4'd1, 1'b0, 32'hF0F0_1234, 32'hFF00_00FF, 16'h0, "R2 andc", 32'h00F0_1200);
        run(4'd2, 1'b0, 32'hABCD_1234, 32'h0, 16'h0F0F, "R3", 32'hABCD_0204);
        run(4'd3, 1'b1, 32'hABCD_1234, 32'h0, 16'h0F0F, "R4", 32'h0B0D_1234);
        run(4'd4, 1'b0, 32'hABCD_1234, 32'h0, 16'h00FF, "R5 lo", 32'h0000_0034);
        run(4'd5, 1'b0, 32'hABCD_1234, 32'h0, 16'hFF00, "R5 hi", 32'hAB00_0000);
        // R6: specifier from src_b, with upper bits of src_b that must be ignored
        run(4'd7, 1'b0, 32'h0000_0F00, 32'hFFFF_FC00 | 32'(spec(4, 8)), 16'h0, "R6 reg spec", 32'h0000_000F);
        run(4'd7, 1'b1, 32'h0000_0F00, 32'h0, 16'hFC00 | spec(4, 8), "R6 imm spec", 32'h0000_000F);
        run(4'd7, 1'b1, 32'h8765_4321, 32'h0, spec(0, 0), "R6 width0=32", 32'h8765_4321);
        run(4'd6, 1'b1, 32'h0000_0080, 32'h0, spec(8, 0), "R8 sign", 32'hFFFF_FF80);
        run(4'd8, 1'b0, 32'hFFFF_FFF5, 32'(spec(4, 12)), 16'h0, "R9", 32'h0000_5000);
        run(4'd9, 1'b1, 32'h0000_0000, 32'h0, spec(8, 28), "R11 set clip", 32'hF000_0000);
        run(4'd6, 1'b1, 32'hA000_0000, 32'h0, spec(8, 28), "R11 exts clip", 32'hFFFF_FFFA);
        run(4'd7, 1'b1, 32'hA000_0000, 32'h0, spec(8, 28), "R11 extu clip", 32'h0000_000A);
        run(4'd10, 1'b0, 32'hFFFF_FFFF, 32'(spec(4, 4)), 16'h0, "R10 clr", 32'hFFFF_FF0F);
        run(4'd8, 1'b1, 32'h0000_00F1, 32'h0, spec(0, 4), "R12 lsl", 32'h0000_0F10);
        run(4'd7, 1'b1, 32'h8000_0000, 32'h0, spec(0, 4), "R12 lsr", 32'h0800_0000);
        run(4'd6, 1'b1, 32'h8000_0000, 32'h0, spec(0, 4), "R12 asr", 32'hF800_0000);
        run(4'd12, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "R13 unused", 32'h0);
        run(4'd0, 1'b0, 32'hFFFF_0000, 32'h00FF_FF00, 16'hAAAA, "R13 use_imm ignored", 32'h00FF_0000);

        for (int n = 0; n < 4000; n++) begin
            logic [3:0]  op;
            logic [31:0] a, b;
            logic [15:0] im;
            logic        ui;
            op = 4'($urandom % 16);
            ui = 1'($urandom);
            a  = $urandom; b = $urandom; im = 16'($urandom);
            run_model(op, ui, a, b, im, req_of(op));
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", result, 32'h0);
        report();
    end

endmodule